// File: doc/BRIEF.md
# Bidirectional Latched Bus Transceiver

This block links two data buses, called side A and side B. Each direction has its own bank of storage, so data from A can be parked for B while data from B is parked for A. Data passes through without inversion. Each direction has three active-low controls. A direction gate must be low for anything to happen in that direction. A capture control makes the bank follow its source bus. An output control lets the bank drive the far bus.

Both buses are modelled as separate input, output and drive-enable signals, so no internal tri-state logic is needed. The storage is clocked. While a bank is open, its output follows the source bus within the same cycle, and the bank loads that value at each clock edge. Once the bank closes, it keeps the value it took at the last edge while it was open.

Top module: `latched_xcvr`

## Requirements
- R1: With `ab_gate_n` and `ab_cap_n` both low, `b_out` equals `a_in` in the same cycle, bit for bit and without inversion, and the bank loads `a_in` at the clock edge.
- R2: With `ab_gate_n` high, the A-to-B bank keeps its contents at every clock edge, whatever `ab_cap_n` is.
- R3: With `ab_cap_n` high, the A-to-B bank keeps its contents at every clock edge.
- R4: When `ab_cap_n` rises while `ab_gate_n` stays low, `b_out` shows the `a_in` value taken at the last edge while the bank was open, and it no longer follows later changes of `a_in`.
- R5: `b_oe` is high exactly when `ab_gate_n` and `ab_drv_n` are both low. `ab_cap_n` has no effect on `b_oe`.
- R6: Whenever the A-to-B bank is not open, `b_out` carries the stored contents, whether or not `b_oe` is high.
- R7: The B-to-A direction (`ba_gate_n`, `ba_cap_n`, `ba_drv_n`, `b_in`, `a_out`, `a_oe`) follows the same rules as R1 to R6. It works independently of the A-to-B direction.
- R8: Both banks can be open at the same time. In that case `b_out` equals `a_in` and `a_out` equals `b_in` in the same cycle.
- R9: Reset clears both banks to zero. After reset, a closed bank presents 0 on its output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ab_gate_n | input | 1 | A-to-B direction gate, active low |
| ab_cap_n | input | 1 | A-to-B capture (transparency) control, active low |
| ab_drv_n | input | 1 | A-to-B output control, active low |
| ba_gate_n | input | 1 | B-to-A direction gate, active low |
| ba_cap_n | input | 1 | B-to-A capture control, active low |
| ba_drv_n | input | 1 | B-to-A output control, active low |
| a_in | input | WIDTH | Data received on side A |
| a_out | output | WIDTH | Data presented toward side A |
| a_oe | output | 1 | Side A drive enable |
| b_in | input | WIDTH | Data received on side B |
| b_out | output | WIDTH | Data presented toward side B |
| b_oe | output | 1 | Side B drive enable |

## Verification
The hardest state to reach is a bank that closes with its capture control while its gate stays low. At that point the bus value keeps changing, and the output must stay fixed at the value taken at the last open edge. The stimulus opens a bank for several cycles with changing data. It then raises only the capture control and keeps changing the source bus. Separate segments open both banks together on unrelated data to show there is no cross-path between the directions. Toggling the gate while capture stays low shows that the gate alone freezes the bank.

// File: rtl/latched_xcvr.sv
module latched_xcvr #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ab_gate_n,
  input  logic             ab_cap_n,
  input  logic             ab_drv_n,
  input  logic             ba_gate_n,
  input  logic             ba_cap_n,
  input  logic             ba_drv_n,
  input  logic [WIDTH-1:0] a_in,
  output logic [WIDTH-1:0] a_out,
  output logic             a_oe,
  input  logic [WIDTH-1:0] b_in,
  output logic [WIDTH-1:0] b_out,
  output logic             b_oe
);

  logic [WIDTH-1:0] ab_q, ba_q;
  logic ab_open, ba_open;

  assign ab_open = !ab_gate_n && !ab_cap_n;
  assign ba_open = !ba_gate_n && !ba_cap_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ab_q <= '0;
    else if (ab_open) ab_q <= a_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ba_q <= '0;
    else if (ba_open) ba_q <= b_in;
  end

  assign b_out = ab_open ? a_in : ab_q;
  assign a_out = ba_open ? b_in : ba_q;
  assign b_oe  = !ab_gate_n && !ab_drv_n;
  assign a_oe  = !ba_gate_n && !ba_drv_n;

  // R2
  ab_gate_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ab_gate_n |=> $stable(ab_q));

  // R3
  ab_cap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ab_cap_n |=> $stable(ab_q));

  // R7
  ba_gate_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ba_gate_n || ba_cap_n) |=> $stable(ba_q));

  // R4
  ab_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(ab_cap_n) && !ab_gate_n && !$past(ab_gate_n)) |-> (b_out == $past(a_in)));

  // R4
  ba_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(ba_cap_n) && !ba_gate_n && !$past(ba_gate_n)) |-> (a_out == $past(b_in)));

  // R5
  b_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ab_drv_n || ab_gate_n) |-> !b_oe);

  // R8
  both_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ab_open && ba_open) |-> (b_out == a_in && a_out == b_in));

endmodule

// File: tb/test_latched_xcvr.sv
module test_latched_xcvr;
  localparam int W = 8;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n;
  logic ab_gate_n, ab_cap_n, ab_drv_n, ba_gate_n, ba_cap_n, ba_drv_n;
  logic [W-1:0] a_in, b_in, a_out, b_out;
  logic a_oe, b_oe;

  latched_xcvr #(.WIDTH(W)) i_latched_xcvr (
    .clk(clk), .rst_n(rst_n),
    .ab_gate_n(ab_gate_n), .ab_cap_n(ab_cap_n), .ab_drv_n(ab_drv_n),
    .ba_gate_n(ba_gate_n), .ba_cap_n(ba_cap_n), .ba_drv_n(ba_drv_n),
    .a_in(a_in), .a_out(a_out), .a_oe(a_oe),
    .b_in(b_in), .b_out(b_out), .b_oe(b_oe)
  );

  int vectors = 0;
  int errs = 0;
  logic [W-1:0] m_ab, m_ba;

  task automatic chk(string req, string what, logic [W-1:0] act, logic [W-1:0] exp);
    vectors++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic step(string req, logic [5:0] ctl, logic [W-1:0] a, logic [W-1:0] b);
    logic ab_o, ba_o;
    @(posedge clk); #1;
    {ab_gate_n, ab_cap_n, ab_drv_n, ba_gate_n, ba_cap_n, ba_drv_n} = ctl;
    a_in = a; b_in = b;
    @(negedge clk);
    ab_o = !ctl[5] && !ctl[4];
    ba_o = !ctl[2] && !ctl[1];
    chk(req, "b_out", b_out, ab_o ? a : m_ab);
    chk(req, "a_out", a_out, ba_o ? b : m_ba);
    chk(req, "b_oe", {7'd0, b_oe}, {7'd0, !ctl[5] && !ctl[3]});
    chk(req, "a_oe", {7'd0, a_oe}, {7'd0, !ctl[2] && !ctl[0]});
    if (ab_o) m_ab = a;
    if (ba_o) m_ba = b;
  endtask

  initial begin
    #(8 * 200000);
    errs++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    {ab_gate_n, ab_cap_n, ab_drv_n, ba_gate_n, ba_cap_n, ba_drv_n} = 6'b111111;
    a_in = 8'h5A; b_in = 8'hA5;
    m_ab = '0; m_ba = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R9: cleared banks, closed
    step("R9", 6'b111111, 8'h3C, 8'hC3);
    step("R9", 6'b010010, 8'h77, 8'h88);
    // R1: A-to-B open, changing data
    step("R1", 6'b001111, 8'h12, 8'h00);
    step("R1", 6'b001111, 8'h34, 8'h00);
    step("R1", 6'b001111, 8'hFE, 8'h00);
    // R4: capture rises, gate low, data keeps moving
    step("R4", 6'b011111, 8'h01, 8'h00);
    step("R4", 6'b010111, 8'h02, 8'h00);
    step("R4", 6'b010111, 8'hFF, 8'h00);
    // R2: gate high, capture low
    step("R2", 6'b100111, 8'h99, 8'h00);
    step("R2", 6'b100111, 8'h66, 8'h00);
    // R6: stored value on b_out with output control high
    step("R6", 6'b011111, 8'hAA, 8'h00);
    // R5: drive qualifiers with capture toggling
    step("R5", 6'b000111, 8'h0F, 8'h00);
    step("R5", 6'b010111, 8'hF0, 8'h00);
    step("R5", 6'b110111, 8'h11, 8'h00);
    step("R5", 6'b001111, 8'h22, 8'h00);
    // R7: B-to-A alone
    step("R7", 6'b111001, 8'h00, 8'h4D);
    step("R7", 6'b111011, 8'h00, 8'h5E);
    step("R7", 6'b111010, 8'h00, 8'h6F);
    step("R7", 6'b111100, 8'h00, 8'h70);
    // R8: both open at once on unrelated data
    step("R8", 6'b001001, 8'hC1, 8'h1C);
    step("R8", 6'b000000, 8'hD2, 8'h2D);
    step("R8", 6'b011011, 8'hE3, 8'h3E);
    // R3: capture high holds in both directions
    step("R3", 6'b010010, 8'h44, 8'h55);
    // R7: mixed random traffic on both directions
    for (int i = 0; i < 400; i++)
      step("R7", 6'($urandom), 8'($urandom), 8'($urandom));
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
    $finish;
  end
endmodule